// File: doc/BRIEF.md
# Pushbutton Press-to-Pulse Conditioner

This block turns the noisy contact of a mechanical pushbutton into one clean, fixed-width pulse per press. The raw contact passes through a short flop chain into the clock domain. A single counter then measures three things in turn: how long the contact stays pressed, how long the output pulse lasts, and a long dead time after each press. While the dead time runs, the input is not looked at, so a user cannot fire the output faster than the dead time allows. After the dead time the block also waits for the button to be let go and to stay let go for the settle time. Only then can a new press count, so a button that is held down gives exactly one pulse.

Both ends have a selectable polarity. The input can come from a button to ground with a pullup, where low means pressed, or from a button that drives high when pressed. The output can be a high-going pulse, or it can sit high at rest and go low for the pulse, which suits a count strobe that is active low. Each time is set in milliseconds and turned into clock cycles from the clock frequency. The cycle counts can also be set directly.

Top module: `press_pulse_gen`

## Requirements
- R1: Right after reset, and until a press is accepted, `pulse_out` rests at its idle level: high when OUT_ACTIVE_LOW=1, low when OUT_ACTIVE_LOW=0.
- R2: A press is accepted only if the synchronized input reads pressed at DEB_CYC+1 consecutive rising edges, starting from the idle state. A raw press held for DEB_CYC+1 clock cycles gives one pulse. A press held for DEB_CYC cycles gives none.
- R3: If the input reads released at any point during the stability count, the count is thrown away and the block goes back to idle. Bursts of short presses separated by releases give no pulse until one press lasts the full window.
- R4: Call the first rising edge that samples the raw input at its pressed level edge 0. For a press that stays down, the output turns active just after edge DEB_CYC+2 and is still idle after edge DEB_CYC+1.
- R5: Each accepted press gives exactly one active output run of PULSE_CYC clock cycles.
- R6: For LOCK_CYC cycles after the pulse ends, the input is ignored. Any press that starts and ends inside this window gives no pulse.
- R7: After the lockout the block returns to idle only once the input has read released at DEB_CYC consecutive edges. A press in this phase restarts that count and never gives a pulse.
- R8: With IN_ACTIVE_LOW=1 a low raw level means pressed. With IN_ACTIVE_LOW=0 a high level means pressed. Apart from that, the timing is the same.
- R9: The output level is the active pulse state XOR OUT_ACTIVE_LOW. The timing does not depend on this polarity.
- R10: The synchronous active-high reset can stop a pulse that is in progress. The output is at its idle level after the next clock edge, and the block accepts a fresh press after reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| btn_raw | input | 1 | Raw button contact, not synchronized. Its polarity is set by IN_ACTIVE_LOW |
| pulse_out | output | 1 | One pulse per accepted press. Its polarity is set by OUT_ACTIVE_LOW |

## Verification
Two of the block's actions can fall on the same clock edge. The first pair is the end of the pulse, which opens the lockout, together with a new press that arrives in those same cycles. The bench sends a second press a few cycles after the first was accepted, so that this press overlaps the switch into lockout. It passes only if the total number of pulses stays at one. The second pair is the end of the lockout together with a button that is still held, or released only briefly and pressed again. There the bench checks that the block stays in its wait-for-release phase and gives no second pulse. A copy of the block with both polarities reversed runs beside the main one, and the two outputs are compared on every cycle.

// File: rtl/pb_pkg.sv
package pb_pkg;

    // Controller phases; encoding is internal only.
    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_DEBOUNCE = 3'd1,
        ST_PULSE    = 3'd2,
        ST_LOCKOUT  = 3'd3,
        ST_WAIT_REL = 3'd4
    } pb_state_e;

    // Command from the controller to the shared interval counter.
    typedef struct packed {
        logic clear;
        logic advance;
    } pb_tmr_ctl_t;

    // Milliseconds to clock cycles, never less than one cycle.
    function automatic int ms_to_cycles(input longint clk_hz, input int ms);
        longint c;
        c = (clk_hz * longint'(ms)) / 64'd1000;
        if (c < 1) c = 1;
        return int'(c);
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    // Counter runs from 0 up to limit-1.
    function automatic int cnt_bits(input int limit);
        return (limit <= 2) ? 1 : $clog2(limit);
    endfunction

endpackage

// File: rtl/pb_sync.sv
module pb_sync #(
    parameter int STAGES        = 2,
    parameter bit IN_ACTIVE_LOW = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic raw,
    output logic pressed
);
    // Level the contact shows when the button is untouched.
    localparam logic IDLE_LVL = IN_ACTIVE_LOW;

    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain <= IDLE_LVL;
                else     chain <= raw;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain <= {STAGES{IDLE_LVL}};
                else     chain <= {chain[STAGES-2:0], raw};
            end
        end
    endgenerate

    // Normalise: 1 means pressed regardless of wiring.
    assign pressed = chain[STAGES-1] ^ IDLE_LVL;

endmodule

// File: rtl/pb_timer.sv
import pb_pkg::*;

module pb_timer #(
    parameter int CW = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  pb_tmr_ctl_t ctl,
    output logic [CW-1:0] count
);
    always_ff @(posedge clk) begin
        if (rst)              count <= '0;
        else if (ctl.clear)   count <= '0;
        else if (ctl.advance) count <= count + CW'(1);
    end
endmodule

// File: rtl/pb_fsm.sv
import pb_pkg::*;

module pb_fsm #(
    parameter int DEB_CYC   = 8,
    parameter int PULSE_CYC = 4,
    parameter int LOCK_CYC  = 20,
    parameter int CW        = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          pressed,
    input  logic [CW-1:0] count,
    output pb_state_e     state_o,
    output pb_tmr_ctl_t   ctl_o
);
    localparam logic [CW-1:0] DEB_LAST   = CW'(DEB_CYC - 1);
    localparam logic [CW-1:0] PULSE_LAST = CW'(PULSE_CYC - 1);
    localparam logic [CW-1:0] LOCK_LAST  = CW'(LOCK_CYC - 1);

    pb_state_e state_q, state_d;
    pb_tmr_ctl_t ctl;

    always_comb begin
        state_d     = state_q;
        ctl.clear   = 1'b0;
        ctl.advance = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                ctl.clear = 1'b1;
                if (pressed) state_d = ST_DEBOUNCE;
            end
            ST_DEBOUNCE: begin
                if (!pressed) begin
                    state_d   = ST_IDLE;
                    ctl.clear = 1'b1;
                end else if (count == DEB_LAST) begin
                    state_d   = ST_PULSE;
                    ctl.clear = 1'b1;
                end else begin
                    ctl.advance = 1'b1;
                end
            end
            ST_PULSE: begin
                if (count == PULSE_LAST) begin
                    state_d   = ST_LOCKOUT;
                    ctl.clear = 1'b1;
                end else begin
                    ctl.advance = 1'b1;
                end
            end
            ST_LOCKOUT: begin
                if (count == LOCK_LAST) begin
                    state_d   = ST_WAIT_REL;
                    ctl.clear = 1'b1;
                end else begin
                    ctl.advance = 1'b1;
                end
            end
            ST_WAIT_REL: begin
                if (pressed) begin
                    ctl.clear = 1'b1;
                end else if (count == DEB_LAST) begin
                    state_d   = ST_IDLE;
                    ctl.clear = 1'b1;
                end else begin
                    ctl.advance = 1'b1;
                end
            end
            default: begin
                state_d   = ST_IDLE;
                ctl.clear = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    assign state_o = state_q;
    assign ctl_o   = ctl;

endmodule

// File: rtl/press_pulse_gen.sv
module press_pulse_gen
    import pb_pkg::*;
#(
    parameter int CLK_HZ         = 1_000_000,
    parameter int DEB_MS         = 50,
    parameter int PULSE_MS       = 2,
    parameter int LOCK_MS        = 500,
    parameter int DEB_CYC        = ms_to_cycles(CLK_HZ, DEB_MS),
    parameter int PULSE_CYC      = ms_to_cycles(CLK_HZ, PULSE_MS),
    parameter int LOCK_CYC       = ms_to_cycles(CLK_HZ, LOCK_MS),
    parameter int SYNC_STAGES    = 2,
    parameter bit IN_ACTIVE_LOW  = 1'b1,
    parameter bit OUT_ACTIVE_LOW = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic btn_raw,
    output logic pulse_out
);
    localparam int CW = cnt_bits(max3(DEB_CYC, PULSE_CYC, LOCK_CYC));

    logic          pressed;
    logic [CW-1:0] tmr_count;
    pb_tmr_ctl_t   tmr_ctl;
    pb_state_e     state_q;

    pb_sync #(
        .STAGES        (SYNC_STAGES),
        .IN_ACTIVE_LOW (IN_ACTIVE_LOW)
    ) u_sync (
        .clk     (clk),
        .rst     (rst),
        .raw     (btn_raw),
        .pressed (pressed)
    );

    pb_timer #(
        .CW (CW)
    ) u_timer (
        .clk   (clk),
        .rst   (rst),
        .ctl   (tmr_ctl),
        .count (tmr_count)
    );

    pb_fsm #(
        .DEB_CYC   (DEB_CYC),
        .PULSE_CYC (PULSE_CYC),
        .LOCK_CYC  (LOCK_CYC),
        .CW        (CW)
    ) u_fsm (
        .clk     (clk),
        .rst     (rst),
        .pressed (pressed),
        .count   (tmr_count),
        .state_o (state_q),
        .ctl_o   (tmr_ctl)
    );

    // Decoded from a register, so the output is glitch free.
    assign pulse_out = (state_q == ST_PULSE) ^ OUT_ACTIVE_LOW;

endmodule

// File: rtl/pb_checker.sv
module pb_checker
    import pb_pkg::*;
#(
    parameter int CW             = 8,
    parameter int PULSE_CYC      = 4,
    parameter int LOCK_CYC       = 20,
    parameter bit OUT_ACTIVE_LOW = 1'b1
) (
    input logic          clk,
    input logic          rst,
    input logic          pulse_out,
    input logic          pressed,
    input pb_state_e     state_q,
    input logic [CW-1:0] tmr_count
);
    logic act;
    assign act = OUT_ACTIVE_LOW ? ~pulse_out : pulse_out;

    AST_REST_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> !act);  // R1

    AST_PULSE_ENTRY: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_PULSE && $past(state_q) != ST_PULSE)
        |-> ($past(state_q) == ST_DEBOUNCE && $past(pressed)));  // R2

    AST_DEB_ABORT: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_DEBOUNCE && !pressed) |=> state_q == ST_IDLE);  // R3

    AST_PULSE_BOUND: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_PULSE) |-> (tmr_count < CW'(PULSE_CYC)));  // R5

    AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_LOCKOUT && tmr_count != CW'(LOCK_CYC - 1))
        |=> (state_q == ST_LOCKOUT && !act));  // R6

    AST_WAIT_RESTART: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WAIT_REL && pressed)
        |=> (state_q == ST_WAIT_REL && tmr_count == '0));  // R7

endmodule

bind press_pulse_gen pb_checker #(
    .CW             (CW),
    .PULSE_CYC      (PULSE_CYC),
    .LOCK_CYC       (LOCK_CYC),
    .OUT_ACTIVE_LOW (OUT_ACTIVE_LOW)
) u_pb_chk (
    .clk       (clk),
    .rst       (rst),
    .pulse_out (pulse_out),
    .pressed   (pressed),
    .state_q   (state_q),
    .tmr_count (tmr_count)
);

// File: tb/tb_press_pulse_gen.sv
`timescale 1ns/1ps
module tb_press_pulse_gen;
    localparam int DEB = 8;
    localparam int PW  = 4;
    localparam int LK  = 20;
    localparam int NV  = 6;

    // {hold1, gap1, hold2, gap2, expected pulses}
    localparam int VEC [NV][5] = '{
        '{ 8, 60,  0,  0, 0},   // R2 one cycle short
        '{ 9, 60,  0,  0, 1},   // R2 just long enough
        '{50, 60,  0,  0, 1},   // R7 held through lockout
        '{ 9,  3,  9, 60, 1},   // R6 second press inside lockout
        '{40,  4, 20, 60, 1},   // R7 brief release then press again
        '{ 9, 60,  9, 60, 2}    // R2 two separate presses
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic press = 1'b0;
    logic raw_n, raw_h, out_n, out_h;
    assign raw_n = ~press;
    assign raw_h = press;

    always #2.5 clk = ~clk;

    press_pulse_gen #(.DEB_CYC(DEB), .PULSE_CYC(PW), .LOCK_CYC(LK),
                      .IN_ACTIVE_LOW(1'b1), .OUT_ACTIVE_LOW(1'b1))
        dut (.clk(clk), .rst(rst), .btn_raw(raw_n), .pulse_out(out_n));

    press_pulse_gen #(.DEB_CYC(DEB), .PULSE_CYC(PW), .LOCK_CYC(LK),
                      .IN_ACTIVE_LOW(1'b0), .OUT_ACTIVE_LOW(1'b0))
        dut_h (.clk(clk), .rst(rst), .btn_raw(raw_h), .pulse_out(out_h));

    int checks = 0;
    int errors = 0;
    int pulses = 0;
    int run    = 0;
    int mism   = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Pulse monitor: width of every run (R5), count of runs, polarity match.
    always @(negedge clk) begin
        if (rst) begin
            run = 0;
        end else begin
            if (out_n == out_h) mism++;
            if (!out_n) run++;
            else if (run != 0) begin
                pulses++;
                check(run == PW, "R5 pulse width", run, PW);
                run = 0;
            end
        end
    end

    task automatic press_for(input int n);
        press = 1'b1;
        repeat (n) @(negedge clk);
        press = 1'b0;
    endtask

    task automatic idle_for(input int n);
        press = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R1 idle levels during and after reset
        repeat (3) @(negedge clk);
        check(out_n == 1'b1, "R1 rest level low-active out in reset", out_n, 1);
        check(out_h == 1'b0, "R1 rest level high-active out in reset", out_h, 0);
        rst = 1'b0;
        repeat (6) @(negedge clk);
        check(out_n == 1'b1 && pulses == 0, "R1 rest after reset", out_n, 1);

        // Vector table
        for (int v = 0; v < NV; v++) begin
            pulses = 0;
            press_for(VEC[v][0]);
            idle_for(VEC[v][1]);
            if (VEC[v][2] > 0) begin
                press_for(VEC[v][2]);
                idle_for(VEC[v][3]);
            end
            check(pulses == VEC[v][4], "R2 R6 R7 vector pulse count", pulses, VEC[v][4]);
        end

        // R4 latency from the first sampling edge
        pulses = 0;
        press = 1'b1;
        @(posedge clk);                  // edge 0
        repeat (DEB + 1) @(posedge clk); // edge DEB+1
        #1;
        check(out_n == 1'b1, "R4 still idle after edge DEB+1", out_n, 1);
        @(posedge clk);                  // edge DEB+2
        #1;
        check(out_n == 1'b0, "R4 active after edge DEB+2", out_n, 0);
        @(negedge clk);
        press_for(2);
        idle_for(60);
        check(pulses == 1, "R4 single pulse", pulses, 1);

        // R3 bouncing contact never completes the window
        pulses = 0;
        for (int b = 0; b < 5; b++) begin
            press_for(6);
            idle_for(1);
        end
        idle_for(30);
        check(pulses == 0, "R3 bounce rejected", pulses, 0);
        for (int b = 0; b < 3; b++) begin
            press_for(5);
            idle_for(1);
        end
        press_for(DEB + 1);
        idle_for(60);
        check(pulses == 1, "R3 bounce then steady", pulses, 1);

        // R10 reset cuts a running pulse
        pulses = 0;
        press = 1'b1;
        for (int w = 0; w < 40 && out_n == 1'b1; w++) @(negedge clk);
        check(out_n == 1'b0, "R10 pulse reached", out_n, 0);
        rst = 1'b1;
        @(negedge clk);
        check(out_n == 1'b1 && out_h == 1'b0, "R10 idle one edge after reset", out_n, 1);
        @(negedge clk);
        press = 1'b0;
        rst = 1'b0;
        idle_for(20);
        check(out_n == 1'b1 && pulses == 0, "R10 stays idle", pulses, 0);
        press_for(DEB + 1);
        idle_for(60);
        check(pulses == 1, "R10 fresh press accepted", pulses, 1);

        // R8 R9 polarity variants behave identically
        check(mism == 0, "R8 R9 polarity mismatch cycles", mism, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule